// File: doc/BRIEF.md
# Serial-to-Parallel Receive Converter with Loopback Selection

This block turns a serial bit stream, clocked by the recovered bit clock, into parallel words. The bits enter a serial-in parallel-out shift register. When a word is complete, it is moved into a separate output holding register. A counter on the bit clock produces a word-rate clock, and that clock falls at the moment the holding register takes a new word.

A source selector feeds the shift register. By default it takes the receive serial line. In diagnostic loopback it takes the transmitter's serial data instead. A change of this selection takes effect only at a word boundary, so a word never mixes bits from the two sources.

A separate registered multiplexer drives the transmit serial data and clock outputs. Normally it passes the serializer's data and clock. In line loopback it passes the receive data and clock, so the received line is sent straight back out.

Top module: `rx_deser_lb`

## Requirements
- R1: While rst_ni is low, pdata_o, pclk_o, tx_sd_o and tx_sclk_o are all 0.
- R2: After reset, pclk_o is low for the first W/2 bit clocks and high for the next W/2, and it repeats with a period of W bit clocks. No level of pclk_o lasts longer than W/2 bit clocks.
- R3: Bits are packed MSB first. The bit sampled at the first edge of a word ends in pdata_o[W-1], and the bit sampled at the W-th edge ends in pdata_o[0].
- R4: pdata_o changes only at the bit clock edge where pclk_o falls. That edge completes the word, and pdata_o holds at all other edges.
- R5: With diagnostic loopback off, words are built from rx_sd_i, and ser_sd_i has no effect on pdata_o.
- R6: With diagnostic loopback on, words are built from ser_sd_i, and rx_sd_i has no effect on pdata_o.
- R7: diag_lb_i is sampled only at the edge that completes a word, and the value sampled there selects the source for the whole next word. Changes in diag_lb_i at other edges have no effect.
- R8: With line_lb_i low, tx_sd_o and tx_sclk_o equal ser_sd_i and ser_sclk_i as sampled at the previous bit clock edge.
- R9: With line_lb_i high, tx_sd_o and tx_sclk_o equal rx_sd_i and rx_sclk_i as sampled at the previous bit clock edge.
- R10: The transmit outputs keep following the source selected by line_lb_i while diagnostic loopback is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_sd_i | input | 1 | Receive serial data |
| rx_sclk_i | input | 1 | Receive serial clock level, sampled as data |
| ser_sd_i | input | 1 | Serializer (transmitter) serial data |
| ser_sclk_i | input | 1 | Serializer serial clock level, sampled as data |
| diag_lb_i | input | 1 | Diagnostic loopback request |
| line_lb_i | input | 1 | Line loopback enable |
| pdata_o | output | W | Parallel output word |
| pclk_o | output | 1 | Word-rate clock; falls when pdata_o loads |
| tx_sd_o | output | 1 | Transmit serial data |
| tx_sclk_o | output | 1 | Transmit serial clock |

## Verification
The bench builds the block with its default word width of 16, which puts every bit slot of a word within reach of a simple sweep. It runs 48 words in which the receive and serializer patterns always differ, so a wrong source choice shows at once. The words include all-zero and all-one patterns. Diagnostic loopback is toggled in the middle of some words and settled at their last bit. Line loopback changes at irregular bit positions. Every bit clock is compared against a model that computes the packing, the clock phase and the loopback latency arithmetically.

// File: rtl/rx_deser_pkg.sv
package rx_deser_pkg;
  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_DIAG = 1'b1
  } rx_src_e;
endpackage

// File: rtl/rx_bit_ctr.sv
module rx_bit_ctr #(
  parameter int W = 16,
  localparam int CNT_W = $clog2(W)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic pclk_o,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign pclk_o = cnt_q[CNT_W-1];
  assign last_o = (cnt_q == CNT_W'(W-1));
endmodule

// File: rtl/rx_src_sel.sv
module rx_src_sel
  import rx_deser_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rx_sd_i,
  input  logic    ser_sd_i,
  input  logic    diag_req_i,
  input  logic    last_i,
  output rx_src_e sel_o,
  output logic    bit_o
);
  rx_src_e sel_q;

  // selection only moves at a word boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SRC_LINE;
    else if (last_i) sel_q <= diag_req_i ? SRC_DIAG : SRC_LINE;
  end

  assign sel_o = sel_q;
  assign bit_o = (sel_q == SRC_DIAG) ? ser_sd_i : rx_sd_i;
endmodule

// File: rtl/rx_sipo.sv
module rx_sipo #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         last_i,
  output logic [W-1:0] sr_o,
  output logic [W-1:0] pdata_o
);
  logic [W-1:0] sr_q, sr_d, hold_q;

  assign sr_d = {sr_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      hold_q <= '0;
    end else begin
      sr_q <= sr_d;
      if (last_i) hold_q <= sr_d;
    end
  end

  assign sr_o    = sr_q;
  assign pdata_o = hold_q;
endmodule

// File: rtl/tx_line_lb.sv
module tx_line_lb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_lb_i,
  input  logic rx_sd_i,
  input  logic rx_sclk_i,
  input  logic ser_sd_i,
  input  logic ser_sclk_i,
  output logic tx_sd_o,
  output logic tx_sclk_o
);
  logic sd_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else if (line_lb_i) begin
      sd_q   <= rx_sd_i;
      sclk_q <= rx_sclk_i;
    end else begin
      sd_q   <= ser_sd_i;
      sclk_q <= ser_sclk_i;
    end
  end

  assign tx_sd_o   = sd_q;
  assign tx_sclk_o = sclk_q;
endmodule

// File: rtl/rx_deser_lb.sv
module rx_deser_lb
  import rx_deser_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_sd_i,
  input  logic         rx_sclk_i,
  input  logic         ser_sd_i,
  input  logic         ser_sclk_i,
  input  logic         diag_lb_i,
  input  logic         line_lb_i,
  output logic [W-1:0] pdata_o,
  output logic         pclk_o,
  output logic         tx_sd_o,
  output logic         tx_sclk_o
);
  logic         word_last;
  logic         src_bit;
  rx_src_e      src_sel;
  logic [W-1:0] sr_q;

  rx_bit_ctr #(.W(W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pclk_o (pclk_o),
    .last_o (word_last)
  );

  rx_src_sel u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_sd_i    (rx_sd_i),
    .ser_sd_i   (ser_sd_i),
    .diag_req_i (diag_lb_i),
    .last_i     (word_last),
    .sel_o      (src_sel),
    .bit_o      (src_bit)
  );

  rx_sipo #(.W(W)) u_sipo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (src_bit),
    .last_i  (word_last),
    .sr_o    (sr_q),
    .pdata_o (pdata_o)
  );

  tx_line_lb u_txlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_lb_i  (line_lb_i),
    .rx_sd_i    (rx_sd_i),
    .rx_sclk_i  (rx_sclk_i),
    .ser_sd_i   (ser_sd_i),
    .ser_sclk_i (ser_sclk_i),
    .tx_sd_o    (tx_sd_o),
    .tx_sclk_o  (tx_sclk_o)
  );
endmodule

// File: rtl/rx_deser_lb_chk.sv
module rx_deser_lb_chk
  import rx_deser_pkg::*;
#(
  parameter int W = 16,
  localparam int HALF = W / 2,
  localparam int RUN_W = $clog2(W) + 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rx_sd_i,
  input logic         rx_sclk_i,
  input logic         ser_sd_i,
  input logic         ser_sclk_i,
  input logic         line_lb_i,
  input logic [W-1:0] pdata_o,
  input logic         pclk_o,
  input logic         tx_sd_o,
  input logic         tx_sclk_o,
  input logic         word_last,
  input logic         src_bit,
  input rx_src_e      src_sel,
  input logic [W-1:0] sr_q
);
  logic             past_ok;
  logic             pclk_d_q;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_ok  <= 1'b0;
      pclk_d_q <= 1'b1;
      run_q    <= '0;
    end else begin
      past_ok  <= 1'b1;
      pclk_d_q <= pclk_o;
      run_q    <= (pclk_o != pclk_d_q) ? '0 : run_q + 1'b1;
    end
  end

  AST_RESET_OUT: assert property (@(posedge clk_i)
    !rst_ni |-> (pdata_o == '0 && !pclk_o && !tx_sd_o && !tx_sclk_o)); // R1

  AST_PCLK_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$stable(pclk_o) |-> run_q == RUN_W'(HALF - 1)); // R2

  AST_PCLK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < RUN_W'(HALF)); // R2

  AST_WORD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $fell(pclk_o) |->
      (pdata_o[0] == $past(src_bit) && pdata_o[W-1:1] == $past(sr_q[W-2:0]))); // R3

  AST_PDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$fell(pclk_o) |-> $stable(pdata_o)); // R4

  AST_SEL_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$stable(src_sel) |-> $past(word_last)); // R7

  AST_TX_SER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(line_lb_i) |->
      (tx_sd_o == $past(ser_sd_i) && tx_sclk_o == $past(ser_sclk_i))); // R8

  AST_TX_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(line_lb_i) |->
      (tx_sd_o == $past(rx_sd_i) && tx_sclk_o == $past(rx_sclk_i))); // R9
endmodule

bind rx_deser_lb rx_deser_lb_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_sd_i    (rx_sd_i),
  .rx_sclk_i  (rx_sclk_i),
  .ser_sd_i   (ser_sd_i),
  .ser_sclk_i (ser_sclk_i),
  .line_lb_i  (line_lb_i),
  .pdata_o    (pdata_o),
  .pclk_o     (pclk_o),
  .tx_sd_o    (tx_sd_o),
  .tx_sclk_o  (tx_sclk_o),
  .word_last  (word_last),
  .src_bit    (src_bit),
  .src_sel    (src_sel),
  .sr_q       (sr_q)
);

// File: tb/rx_deser_lb_tb.sv
`timescale 1ns/1ps
module rx_deser_lb_tb;
  localparam int W  = 16;
  localparam int NW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sd = 1'b0, rx_sclk = 1'b0, ser_sd = 1'b0, ser_sclk = 1'b0;
  logic diag = 1'b0, line = 1'b0;
  logic [W-1:0] pdata;
  logic pclk, tx_sd, tx_sclk;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] m_sr = '0, m_dout = '0;
  int           m_cnt = 0;
  logic         m_sel = 1'b0;
  logic         m_tsd = 1'b0, m_tsck = 1'b0;

  always #2 clk = ~clk;

  rx_deser_lb #(.W(W)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_sd_i    (rx_sd),
    .rx_sclk_i  (rx_sclk),
    .ser_sd_i   (ser_sd),
    .ser_sclk_i (ser_sclk),
    .diag_lb_i  (diag),
    .line_lb_i  (line),
    .pdata_o    (pdata),
    .pclk_o     (pclk),
    .tx_sd_o    (tx_sd),
    .tx_sclk_o  (tx_sclk)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bit slot, advance one edge, update model, compare at the negedge
  task automatic step(input logic rx, input logic ser, input logic rck, input logic sck,
                      input logic dg, input logic ll, input bit noisy);
    logic b;
    bit   boundary;
    logic used_sel;
    rx_sd = rx; ser_sd = ser; rx_sclk = rck; ser_sclk = sck; diag = dg; line = ll;
    @(posedge clk);
    used_sel = m_sel;
    b = m_sel ? ser : rx;
    m_sr = {m_sr[W-2:0], b};
    boundary = (m_cnt == W-1);
    if (boundary) begin
      m_dout = m_sr;
      m_sel  = dg;
    end
    m_cnt  = (m_cnt + 1) % W;
    m_tsd  = ll ? rx : ser;
    m_tsck = ll ? rck : sck;
    @(negedge clk);
    chk("R2", W'(pclk), W'(m_cnt >= W/2));
    if (!boundary)  chk("R4", pdata, m_dout);
    else if (noisy) chk("R7", pdata, m_dout);
    else if (used_sel) chk("R6 R3", pdata, m_dout);
    else            chk("R5 R3", pdata, m_dout);
    if (ll)         chk("R9", W'({tx_sd, tx_sclk}), W'({m_tsd, m_tsck}));
    else if (used_sel) chk("R10", W'({tx_sd, tx_sclk}), W'({m_tsd, m_tsck}));
    else            chk("R8", W'({tx_sd, tx_sclk}), W'({m_tsd, m_tsck}));
  endtask

  initial begin
    logic [W-1:0] rxw, serw;
    logic d;
    bit noisy;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rx_sd = 1'b1; ser_sd = 1'b1; rx_sclk = 1'b1; ser_sclk = 1'b1; line = 1'b1;
    @(negedge clk);
    // R1: outputs held at zero while reset is low
    chk("R1", pdata, '0);
    chk("R1", W'({pclk, tx_sd, tx_sclk}), '0);
    rst_n = 1'b1;
    for (int k = 0; k < NW; k++) begin
      if (k == 0)      rxw = '0;
      else if (k == 1) rxw = '1;
      else             rxw = W'(16'hA5C3 ^ (k * 16'h1357));
      serw  = {rxw[W/2-1:0], rxw[W-1:W/2]} ^ W'(16'h5A5A);
      d     = k[1] ^ k[3];
      noisy = k[0];
      for (int b = 0; b < W; b++) begin
        step(rxw[W-1-b], serw[W-1-b], b[0], ~b[1],
             (noisy && b >= 3 && b <= W-4) ? ~d : d,
             ((k + b) % 3) == 0, noisy);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule